// File: doc/BRIEF.md
# Serial NOR Flash Command Framer

This block is the target-side front end of a serial NOR flash. It runs on the system clock and passes chip select, serial clock and serial input through short synchronisers. It takes one bit of serial input on each rising serial-clock edge while chip select is low, and gathers the bits into bytes, most significant bit first. The first byte is the instruction. For a recognised instruction in the four-byte-address family, the next 32 bits form the target address, and the first address byte received is the most significant byte.

When chip select goes high, the framer decides what happens to the transaction. A well-formed command produces a one-cycle valid pulse. The pulse carries the operation class (read, program or erase), the bus width the data phase would use, a double-data-rate flag and the captured address. A downstream memory-access stub uses these fields. A command that ends off a byte boundary, or that ends before its address is complete, raises an error pulse instead. An unknown instruction byte marks the rest of the transaction as ignored.

The framer also shows which IO lanes the device would drive during the data phase of a read. The real dual, quad and double-rate data transfers, the memory array and all status handling are left to other blocks.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset, every output is 0: cmd_valid, cmd_class, cmd_width, cmd_ddr, cmd_addr, frame_err, cmd_ignored and dev_drive.
- R2: Serial-clock rising edges that arrive while cs_n is high have no effect. Bit counting for a transaction starts from zero at each falling edge of cs_n.
- R3: The single-rate read opcodes decode to class 0 (read) with ddr 0. Opcodes 0x13 and 0x0C give width 1. Opcodes 0x3C and 0xBC give width 2. Opcodes 0x6C and 0xEC give width 4. The width field holds the lane count as a number (1, 2 or 4).
- R4: The double-rate read opcodes decode to class 0 with ddr 1: 0x0E gives width 1, 0xBE gives width 2 and 0xEE gives width 4.
- R5: Program opcode 0x12 gives class 1 with width 1. Program opcode 0x34 gives class 1 with width 4. Erase opcodes 0x21 and 0xDC give class 2 with width 1. All four have ddr 0.
- R6: The opcode is received MSB first. The 32 bits after it are cmd_addr, MSB first, so the first address byte received is bits 31:24.
- R7: cmd_valid is a single-cycle pulse. It is raised when cs_n rises after a recognised opcode, the full address, and a total bit count that is a multiple of 8. The class, width, ddr and address fields keep their values until the next cmd_valid.
- R8: If cs_n rises after a recognised opcode, or during the opcode byte, at a bit count that is not a multiple of 8, frame_err pulses for one cycle. In that case no cmd_valid is raised and the command fields are unchanged.
- R9: If cs_n rises at a nonzero multiple of 8 bits but before the 32-bit address is complete, frame_err pulses and no cmd_valid is raised.
- R10: An opcode outside the table sets cmd_ignored as soon as its eighth bit is taken. cmd_ignored stays high until cs_n rises. Such a transaction produces neither cmd_valid nor frame_err, however many bits follow.
- R11: dev_drive is nonzero only after the address of a recognised read, while cs_n is still low. The values are 4'b0010 for width 1, 4'b0011 for width 2 and 4'b1111 for width 4. Program and erase commands keep it at 0.
- R12: A cs_n low period with no serial-clock edges produces neither cmd_valid nor frame_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select from the host |
| si | input | 1 | Serial input (IO0) from the host |
| cmd_valid | output | 1 | One-cycle pulse for a well-formed command |
| cmd_class | output | 2 | 0 read, 1 program, 2 erase |
| cmd_width | output | 3 | Data-phase lane count: 1, 2 or 4 |
| cmd_ddr | output | 1 | Double-data-rate read |
| cmd_addr | output | 32 | Captured four-byte address |
| frame_err | output | 1 | One-cycle pulse for a misframed or truncated command |
| cmd_ignored | output | 1 | Unknown opcode in the current transaction |
| dev_drive | output | 4 | Lanes the device drives in the read data phase |

## Verification
The bench ends transactions one, three and five bits off a byte boundary, both in the opcode and after the address. A framer that did not check the bit count modulo 8 would report these as good commands carrying a shifted address. The bench also ends transactions exactly on a byte boundary that still falls short of the address, to catch a design that checks alignment but not completeness. An unknown opcode followed by a ragged tail must stay silent; a design that checked framing before checking the ignore state would raise a false error here. The bench toggles the serial clock while chip select is high, and a design that counted those edges would misalign every later byte. It also checks dev_drive in the data phase of each width, and checks that it stays 0 for program commands.

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer #(
  parameter int SYNC       = 2,
  parameter int ADDR_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk,
  input  logic                    cs_n,
  input  logic                    si,
  output logic                    cmd_valid,
  output logic [1:0]              cmd_class,
  output logic [2:0]              cmd_width,
  output logic                    cmd_ddr,
  output logic [8*ADDR_BYTES-1:0] cmd_addr,
  output logic                    frame_err,
  output logic                    cmd_ignored,
  output logic [3:0]              dev_drive
);
  localparam int AW  = 8 * ADDR_BYTES;
  localparam int HDR = 8 + AW;
  localparam int CW  = $clog2(HDR + 1);
  localparam logic [CW-1:0] HDR_C = CW'(HDR);
  localparam logic [CW-1:0] OPC_C = CW'(8);

  logic [SYNC-1:0] sck_p, csn_p, si_p;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      csn_p <= '1;
      si_p  <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_p <= {sck_p[SYNC-2:0], sclk};
      csn_p <= {csn_p[SYNC-2:0], cs_n};
      si_p  <= {si_p[SYNC-2:0], si};
      sck_d <= sck_p[SYNC-1];
      cs_d  <= csn_p[SYNC-1];
    end
  end

  wire cs_s     = csn_p[SYNC-1];
  wire si_s     = si_p[SYNC-1];
  wire sck_rise = sck_p[SYNC-1] & ~sck_d & ~cs_s;
  wire cs_rise  = cs_s & ~cs_d;

  // {hit, class[1:0], width[2:0], ddr}
  function automatic logic [6:0] decode(input logic [7:0] op);
    case (op)
      8'h13, 8'h0C: decode = {1'b1, 2'd0, 3'd1, 1'b0};
      8'h3C, 8'hBC: decode = {1'b1, 2'd0, 3'd2, 1'b0};
      8'h6C, 8'hEC: decode = {1'b1, 2'd0, 3'd4, 1'b0};
      8'h0E:        decode = {1'b1, 2'd0, 3'd1, 1'b1};
      8'hBE:        decode = {1'b1, 2'd0, 3'd2, 1'b1};
      8'hEE:        decode = {1'b1, 2'd0, 3'd4, 1'b1};
      8'h12:        decode = {1'b1, 2'd1, 3'd1, 1'b0};
      8'h34:        decode = {1'b1, 2'd1, 3'd4, 1'b0};
      8'h21, 8'hDC: decode = {1'b1, 2'd2, 3'd1, 1'b0};
      default:      decode = 7'd0;
    endcase
  endfunction

  logic [CW-1:0] cnt;
  logic [2:0]    mod8;
  logic [6:0]    opc;
  logic          known, ignored, ddr_r;
  logic [1:0]    cls_r;
  logic [2:0]    wid_r;
  logic [AW-1:0] addr_sh;

  wire [6:0] dec = decode({opc, si_s});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      mod8    <= '0;
      opc     <= '0;
      known   <= 1'b0;
      ignored <= 1'b0;
      cls_r   <= '0;
      wid_r   <= '0;
      ddr_r   <= 1'b0;
      addr_sh <= '0;
    end else if (cs_s) begin
      cnt     <= '0;
      mod8    <= '0;
      known   <= 1'b0;
      ignored <= 1'b0;
    end else if (sck_rise) begin
      mod8 <= mod8 + 3'd1;
      if (cnt != HDR_C) cnt <= cnt + 1'b1;
      if (cnt < OPC_C) opc <= {opc[5:0], si_s};
      if (cnt == OPC_C - 1'b1) begin
        known   <= dec[6];
        ignored <= ~dec[6];
        cls_r   <= dec[5:4];
        wid_r   <= dec[3:1];
        ddr_r   <= dec[0];
      end else if (known && cnt >= OPC_C && cnt < HDR_C) begin
        addr_sh <= {addr_sh[AW-2:0], si_s};
      end
    end
  end

  wire good_end = cs_rise & known & (cnt == HDR_C) & (mod8 == 3'd0);
  wire bad_end  = cs_rise & ~ignored & (cnt != '0) & ((mod8 != 3'd0) | (cnt != HDR_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      frame_err <= 1'b0;
      cmd_class <= '0;
      cmd_width <= '0;
      cmd_ddr   <= 1'b0;
      cmd_addr  <= '0;
    end else begin
      cmd_valid <= good_end;
      frame_err <= bad_end;
      if (good_end) begin
        cmd_class <= cls_r;
        cmd_width <= wid_r;
        cmd_ddr   <= ddr_r;
        cmd_addr  <= addr_sh;
      end
    end
  end

  assign cmd_ignored = ignored;

  wire [3:0] lanes = (wid_r == 3'd4) ? 4'b1111 : (wid_r == 3'd2) ? 4'b0011 : 4'b0010;
  assign dev_drive = (~cs_s & known & (cls_r == 2'd0) & (cnt == HDR_C)) ? lanes : 4'b0000;

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R8
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && frame_err));

  // R7
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_addr) && $stable(cmd_class) && $stable(cmd_width));

  // R4
  ddr_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ddr) |-> cmd_class == 2'd0);

  // R10
  ignored_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ignored |=> !cmd_valid && !frame_err);

  // R11
  drive_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_drive == 4'b0000) || (dev_drive == 4'b0010) ||
    (dev_drive == 4'b0011) || (dev_drive == 4'b1111));

  // R11
  drive_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_drive) |-> !cmd_ignored);
endmodule

// File: tb/spi_cmd_framer_tb.sv
module spi_cmd_framer_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic        cmd_valid, cmd_ddr, frame_err, cmd_ignored;
  logic [1:0]  cmd_class;
  logic [2:0]  cmd_width;
  logic [31:0] cmd_addr;
  logic [3:0]  dev_drive;

  always #(CLK_P/2) clk = ~clk;

  spi_cmd_framer u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .cmd_valid(cmd_valid), .cmd_class(cmd_class), .cmd_width(cmd_width),
    .cmd_ddr(cmd_ddr), .cmd_addr(cmd_addr), .frame_err(frame_err),
    .cmd_ignored(cmd_ignored), .dev_drive(dev_drive)
  );

  typedef struct {
    bit          is_err;
    logic [1:0]  cls;
    logic [2:0]  wid;
    logic        ddr;
    logic [31:0] addr;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0]  h_cls  = '0;
  logic [2:0]  h_wid  = '0;
  logic        h_ddr  = 1'b0;
  logic [31:0] h_addr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (cmd_valid || frame_err)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10/R12", "unexpected event {valid,err}",
              {62'd0, cmd_valid, frame_err}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cmd_valid == !e.is_err && frame_err == e.is_err, e.req, "event {valid,err}",
              {62'd0, cmd_valid, frame_err}, {62'd0, !e.is_err, e.is_err});
        check(cmd_class == e.cls && cmd_width == e.wid && cmd_ddr == e.ddr, e.req,
              "{class,width,ddr}", {58'd0, cmd_class, cmd_width, cmd_ddr},
              {58'd0, e.cls, e.wid, e.ddr});
        check(cmd_addr == e.addr, e.req, "address", {32'd0, cmd_addr}, {32'd0, e.addr});
      end
    end
  end

  task automatic push_ok(input logic [1:0] c, input logic [2:0] w, input logic d,
                         input logic [31:0] a, input string req);
    exp_t e;
    e.is_err = 0; e.cls = c; e.wid = w; e.ddr = d; e.addr = a; e.req = req;
    exp_q.push_back(e);
    h_cls = c; h_wid = w; h_ddr = d; h_addr = a;
  endtask

  task automatic push_err(input string req);
    exp_t e;
    e.is_err = 1; e.cls = h_cls; e.wid = h_wid; e.ddr = h_ddr; e.addr = h_addr; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b);
    si = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic shift(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) spi_bit(v[i]);
  endtask

  task automatic sel;
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic full_cmd(input logic [7:0] op, input logic [31:0] a,
                          input logic [1:0] c, input logic [2:0] w, input logic d,
                          input string req);
    push_ok(c, w, d, a, req);
    sel();
    shift({56'd0, op}, 8);
    shift({32'd0, a}, 32);
    desel();
  endtask

  initial begin
    wait_clk(5);
    // R1
    check(cmd_valid == 0 && frame_err == 0 && cmd_ignored == 0 && dev_drive == 0 &&
          cmd_addr == 0 && cmd_class == 0 && cmd_width == 0 && cmd_ddr == 0,
          "R1", "reset outputs", {cmd_valid, frame_err, cmd_ignored, dev_drive, cmd_addr}, 64'd0);
    rst_n = 1'b1;
    wait_clk(5);

    // R3 single-rate reads, R6 address ordering
    full_cmd(8'h13, 32'h1234_5678, 2'd0, 3'd1, 1'b0, "R6");
    full_cmd(8'h0C, 32'h8000_0001, 2'd0, 3'd1, 1'b0, "R3");
    full_cmd(8'h3C, 32'hFFFF_FFFE, 2'd0, 3'd2, 1'b0, "R3");
    full_cmd(8'hBC, 32'h0000_0000, 2'd0, 3'd2, 1'b0, "R3");
    full_cmd(8'h6C, 32'hA5C3_0F96, 2'd0, 3'd4, 1'b0, "R3");
    full_cmd(8'hEC, 32'h0102_0304, 2'd0, 3'd4, 1'b0, "R3");
    // R4 double-rate reads
    full_cmd(8'h0E, 32'hDEAD_BEEF, 2'd0, 3'd1, 1'b1, "R4");
    full_cmd(8'hBE, 32'h7654_3210, 2'd0, 3'd2, 1'b1, "R4");
    full_cmd(8'hEE, 32'h0F0F_F0F0, 2'd0, 3'd4, 1'b1, "R4");
    // R5 program and erase
    full_cmd(8'h12, 32'h0000_0100, 2'd1, 3'd1, 1'b0, "R5");
    full_cmd(8'h34, 32'h0001_0000, 2'd1, 3'd4, 1'b0, "R5");
    full_cmd(8'h21, 32'h0000_1000, 2'd2, 3'd1, 1'b0, "R5");
    full_cmd(8'hDC, 32'h0100_0000, 2'd2, 3'd1, 1'b0, "R5");

    // R7 fields held after the pulse
    wait_clk(20);
    check(cmd_addr == 32'h0100_0000 && cmd_class == 2'd2 && cmd_valid == 0, "R7",
          "held fields", {30'd0, cmd_class, cmd_addr}, {30'd0, 2'd2, 32'h0100_0000});

    // R8 misaligned release after the address
    push_err("R8");
    sel(); shift(64'h13, 8); shift(64'h5555_AAAA, 32); shift(64'h5, 3); desel();
    // R8 misaligned release inside the opcode
    push_err("R8");
    sel(); shift(64'h1F, 5); desel();
    // R8 one bit past an aligned boundary
    push_err("R8");
    sel(); shift(64'h6C, 8); shift(64'h1111_2222, 32); shift(64'h1, 1); desel();

    // R9 aligned but truncated
    push_err("R9");
    sel(); shift(64'h0C, 8); shift(64'hABCD, 16); desel();
    push_err("R9");
    sel(); shift(64'h12, 8); desel();

    // R10 unknown opcode, ragged tail
    sel(); shift(64'h03, 8);
    wait_clk(6);
    check(cmd_ignored == 1'b1, "R10", "ignored set", {63'd0, cmd_ignored}, 64'd1);
    shift(64'h12_3456, 24); shift(64'h3, 5);
    desel();
    check(cmd_ignored == 1'b0, "R10", "ignored cleared", {63'd0, cmd_ignored}, 64'd0);

    // R11 lanes driven in read data phase
    push_ok(2'd0, 3'd2, 1'b0, 32'h0000_00AA, "R11");
    sel(); shift(64'h3C, 8); shift(64'hAA, 32);
    wait_clk(6);
    check(dev_drive == 4'b0011, "R11", "dual lanes", {60'd0, dev_drive}, 64'h3);
    shift(64'h00, 8); desel();
    check(dev_drive == 4'b0000, "R11", "lanes after release", {60'd0, dev_drive}, 64'h0);

    push_ok(2'd0, 3'd4, 1'b0, 32'h0000_00BB, "R11");
    sel(); shift(64'h6C, 8); shift(64'hBB, 32);
    wait_clk(6);
    check(dev_drive == 4'b1111, "R11", "quad lanes", {60'd0, dev_drive}, 64'hF);
    desel();

    push_ok(2'd0, 3'd1, 1'b0, 32'h0000_00CC, "R11");
    sel(); shift(64'h13, 8);
    wait_clk(6);
    check(dev_drive == 4'b0000, "R11", "no drive in address", {60'd0, dev_drive}, 64'h0);
    shift(64'hCC, 32);
    wait_clk(6);
    check(dev_drive == 4'b0010, "R11", "single lane", {60'd0, dev_drive}, 64'h2);
    desel();

    push_ok(2'd1, 3'd4, 1'b0, 32'h0000_00DD, "R11");
    sel(); shift(64'h34, 8); shift(64'hDD, 32);
    wait_clk(6);
    check(dev_drive == 4'b0000, "R11", "program no drive", {60'd0, dev_drive}, 64'h0);
    shift(64'h77, 8); desel();

    // R12 select with no clocks
    sel(); wait_clk(10); desel();

    // R2 clocks while deselected are not counted
    shift(64'h7, 3);
    full_cmd(8'hEC, 32'hCAFE_F00D, 2'd0, 3'd4, 1'b0, "R2");

    wait_clk(20);
    check(exp_q.size() == 0, "R7", "pending expected events", 64'(exp_q.size()), 64'd0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule